// File: doc/BRIEF.md
# Register-Controlled Clock Source Selector

This block picks one of several incoming clocks and forwards it on a single output. Software chooses the source by writing a 32-bit control word on the register clock. A selector field inside that word names the wanted source. At build time the field can be read in one of three ways: as a plain index counted from zero, as an index counted from one, or as a one-hot vector.

Two optional build modes change how writes land. In half-word mask mode, only the low 16 bits hold settings, and each upper bit gates the write of its partner bit below. In locked mode, writes have no effect at all. A write whose field names no real source is dropped whole.

Changing source never produces a short pulse on the output. The old source's gate closes on that source's own falling edge. Only after the close has been seen back in the register domain is the new gate opened, again on its own falling edge. A busy flag covers the whole exchange. The reported active index moves only at the end.

Top module: `clksrc_sel_mux`

## Requirements
- R1: After reset, the control word holds the code for source 0 (0 in zero-based mode, 1 at the field position otherwise). The active index is 0, busy is high until the gate of source 0 has opened, and the output then follows source 0.
- R2: In zero-based mode, the field occupies bits [FIELD_SHIFT+FIELD_W-1:FIELD_SHIFT]. A field value k below NUM_SRC selects source k. Bits outside the field are stored and read back unchanged.
- R3: In one-based mode, a field value k from 1 to NUM_SRC selects source k-1.
- R4: In one-hot mode, a field with exactly bit k set, where k is below NUM_SRC, selects source k.
- R5: A write whose resulting field names no source is ignored. This covers a value out of range, a zero in one-based mode, and zero or several bits set in one-hot mode. The stored word and the selection stay as they were.
- R6: In half-word mask mode, bit i of the low half is replaced by write bit i only when write bit 16+i is 1. The upper 16 bits of the stored word read back as 0.
- R7: In locked mode, no write changes the stored word, the busy flag or the active index.
- R8: A write accepted with a new source raises busy two register-clock edges after the write edge. The active index holds its old value while busy is high. When busy falls, the active index equals the requested source.
- R9: No output pulse, high or low, is shorter than half the period of the fastest source. Once a switch is done, the output period equals the period of the selected source, and at most one source gate is open.
- R10: A write that selects the source already active starts no switch, and busy stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Write data; in half-word mask mode, bits 31:16 are per-bit enables |
| sel_reg | output | 32 | Read-back of the stored control word |
| src_clk | input | NUM_SRC | Candidate source clocks |
| clk_out | output | 1 | Selected, glitch-free output clock |
| switch_busy | output | 1 | High while a source change is in progress |
| active_idx | output | IDX_W | Index of the source currently driving the output |

## Verification
Some properties are checked on every register-clock cycle: that at most one synchronized gate acknowledge is high, that the active index does not move while busy, that busy falls only with the target gate acknowledged, and that a rejected or locked write leaves the stored word untouched. Other behaviour can only be shown by the bench scenarios. These include the three field decodings with their boundary values, the half-word masking of partial updates, the two-edge latency of busy, and the real-time shape of the output clock: its period after each switch, and the absence of short pulses measured at every output edge.

// File: rtl/clksel_pkg.sv
package clksel_pkg;
  // how the selector field is interpreted
  typedef enum logic [1:0] {
    SEL_ZERO   = 2'd0,
    SEL_ONE    = 2'd1,
    SEL_ONEHOT = 2'd2
  } sel_mode_e;

  // switch sequencer states
  typedef enum logic [1:0] {
    SW_IDLE  = 2'd0,
    SW_DRAIN = 2'd1,
    SW_FILL  = 2'd2
  } sw_state_e;
endpackage

// File: rtl/clksel_regs.sv
module clksel_regs
  import clksel_pkg::*;
#(
  parameter int        NUM_SRC     = 4,
  parameter sel_mode_e SEL_MODE    = SEL_ZERO,
  parameter int        FIELD_SHIFT = 0,
  parameter int        FIELD_W     = 4,
  parameter bit        HALF_MASK   = 1'b0,
  parameter bit        LOCKED      = 1'b0,
  parameter int        IDX_W       = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  output logic [31:0]      ctrl_q,
  output logic [IDX_W-1:0] req_idx
);
  localparam logic [FIELD_W-1:0] FIELD_RST = (SEL_MODE == SEL_ZERO) ? '0 : FIELD_W'(1);
  localparam logic [31:0]        CTRL_RST  = 32'(FIELD_RST) << FIELD_SHIFT;

  logic [31:0]        cand;
  logic [FIELD_W-1:0] fld;
  logic               cand_ok;
  logic [IDX_W-1:0]   cand_idx;

  // candidate word after applying the write policy
  generate
    if (HALF_MASK) begin : g_half
      always_comb begin
        cand = ctrl_q;
        for (int b = 0; b < 16; b++) begin
          if (wr_data[16+b]) cand[b] = wr_data[b];
        end
        cand[31:16] = '0;
      end
    end else begin : g_full
      assign cand = wr_data;
    end
  endgenerate

  assign fld = cand[FIELD_SHIFT +: FIELD_W];

  // field decode
  always_comb begin
    cand_ok  = 1'b0;
    cand_idx = '0;
    if (SEL_MODE == SEL_ZERO) begin
      if (32'(fld) < 32'(NUM_SRC)) begin
        cand_ok  = 1'b1;
        cand_idx = IDX_W'(fld);
      end
    end else if (SEL_MODE == SEL_ONE) begin
      if ((fld != '0) && (32'(fld) <= 32'(NUM_SRC))) begin
        cand_ok  = 1'b1;
        cand_idx = IDX_W'(fld - 1'b1);
      end
    end else begin
      if ($countones(fld) == 1) begin
        for (int k = 0; k < FIELD_W; k++) begin
          if (fld[k] && (k < NUM_SRC)) begin
            cand_ok  = 1'b1;
            cand_idx = IDX_W'(k);
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= CTRL_RST;
      req_idx <= '0;
    end else if (wr_en && !LOCKED && cand_ok) begin
      ctrl_q  <= cand;
      req_idx <= cand_idx;
    end
  end

  // R5: a write that decodes to no source leaves everything in place
  assert_bad_sel_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !cand_ok) |=> ($stable(ctrl_q) && $stable(req_idx)));

  generate
    if (LOCKED) begin : g_lock_chk
      // R7: locked word never moves
      assert_locked_word_R7: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> $stable(ctrl_q));
    end
  endgenerate
endmodule

// File: rtl/clksel_gate_cell.sv
module clksel_gate_cell #(
  parameter int SYNC_STAGES = 2
) (
  input  logic src_clk,
  input  logic rst,
  input  logic en_req,
  output logic gate_en
);
  logic [SYNC_STAGES-1:0] sync_q;

  // bring the request into the source domain
  always_ff @(posedge src_clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], en_req};
  end

  // change the gate only while the source is low
  always_ff @(negedge src_clk) begin
    if (rst) gate_en <= 1'b0;
    else     gate_en <= sync_q[SYNC_STAGES-1];
  end
endmodule

// File: rtl/clksel_ctrl.sv
module clksel_ctrl
  import clksel_pkg::*;
#(
  parameter int NUM_SRC     = 4,
  parameter int SYNC_STAGES = 2,
  parameter int IDX_W       = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [IDX_W-1:0]   req_idx,
  input  logic [NUM_SRC-1:0] gate_en,
  output logic [NUM_SRC-1:0] en_req,
  output logic               busy,
  output logic [IDX_W-1:0]   active_idx
);
  logic [NUM_SRC-1:0] ack;
  sw_state_e          st;
  logic [IDX_W-1:0]   tgt_idx;

  // gate state brought back into the register domain
  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_ack
      logic [SYNC_STAGES-1:0] sr;
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[SYNC_STAGES-2:0], gate_en[i]};
      end
      assign ack[i] = sr[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= SW_FILL;
      tgt_idx    <= '0;
      active_idx <= '0;
      en_req     <= NUM_SRC'(1);
    end else begin
      case (st)
        SW_IDLE: begin
          if (req_idx != active_idx) begin
            en_req  <= '0;
            tgt_idx <= req_idx;
            st      <= SW_DRAIN;
          end
        end
        SW_DRAIN: begin
          if (!ack[active_idx]) begin
            en_req <= NUM_SRC'(1) << tgt_idx;
            st     <= SW_FILL;
          end
        end
        SW_FILL: begin
          if (ack[tgt_idx]) begin
            active_idx <= tgt_idx;
            st         <= SW_IDLE;
          end
        end
        default: st <= SW_IDLE;
      endcase
    end
  end

  assign busy = (st != SW_IDLE);

  // R9: never two gates open at once
  assert_one_gate_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ack));

  // R8: reported source frozen during a switch
  assert_idx_hold_R8: assert property (@(posedge clk) disable iff (rst)
    busy |-> $stable(active_idx));

  // R8: switch ends only with the new gate confirmed open
  assert_done_acked_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ack[active_idx]);
endmodule

// File: rtl/clksrc_sel_mux.sv
module clksrc_sel_mux
  import clksel_pkg::*;
#(
  parameter int        NUM_SRC     = 4,
  parameter sel_mode_e SEL_MODE    = SEL_ZERO,
  parameter int        FIELD_SHIFT = 0,
  parameter int        FIELD_W     = 4,
  parameter bit        HALF_MASK   = 1'b0,
  parameter bit        LOCKED      = 1'b0,
  parameter int        SYNC_STAGES = 2,
  localparam int       IDX_W       = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [31:0]        wr_data,
  output logic [31:0]        sel_reg,
  input  logic [NUM_SRC-1:0] src_clk,
  output logic               clk_out,
  output logic               switch_busy,
  output logic [IDX_W-1:0]   active_idx
);
  logic [IDX_W-1:0]   req_idx;
  logic [NUM_SRC-1:0] en_req;
  logic [NUM_SRC-1:0] gate_en;

  clksel_regs #(
    .NUM_SRC(NUM_SRC), .SEL_MODE(SEL_MODE), .FIELD_SHIFT(FIELD_SHIFT),
    .FIELD_W(FIELD_W), .HALF_MASK(HALF_MASK), .LOCKED(LOCKED), .IDX_W(IDX_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .ctrl_q(sel_reg), .req_idx(req_idx)
  );

  clksel_ctrl #(
    .NUM_SRC(NUM_SRC), .SYNC_STAGES(SYNC_STAGES), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .req_idx(req_idx), .gate_en(gate_en),
    .en_req(en_req), .busy(switch_busy), .active_idx(active_idx)
  );

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_cell
      clksel_gate_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
        .src_clk(src_clk[i]), .rst(rst), .en_req(en_req[i]), .gate_en(gate_en[i])
      );
    end
  endgenerate

  assign clk_out = |(src_clk & gate_en);
endmodule

// File: tb/test_clksrc_sel_mux.sv
`timescale 1ns/1ps
module test_clksrc_sel_mux;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] src = '0;
  logic [3:0] we = '0;
  logic [31:0] wdata = '0;

  always #4 clk = ~clk;
  always #5 src[0] = ~src[0];
  always #6 src[1] = ~src[1];
  always #9 src[2] = ~src[2];
  always #13 src[3] = ~src[3];

  logic [31:0] sel_a, sel_b, sel_c, sel_d;
  logic        busy_a, busy_b, busy_c, busy_d;
  logic        out_a, out_b, out_c, out_d;
  logic [1:0]  act_a, act_b, act_c, act_d;

  clksrc_sel_mux #(.SEL_MODE(clksel_pkg::SEL_ZERO), .FIELD_SHIFT(4), .FIELD_W(4)) i_clksrc_sel_mux (
    .clk(clk), .rst(rst), .wr_en(we[0]), .wr_data(wdata), .sel_reg(sel_a),
    .src_clk(src), .clk_out(out_a), .switch_busy(busy_a), .active_idx(act_a));
  clksrc_sel_mux #(.SEL_MODE(clksel_pkg::SEL_ONE), .FIELD_SHIFT(0), .FIELD_W(3)) i_onebased (
    .clk(clk), .rst(rst), .wr_en(we[1]), .wr_data(wdata), .sel_reg(sel_b),
    .src_clk(src), .clk_out(out_b), .switch_busy(busy_b), .active_idx(act_b));
  clksrc_sel_mux #(.SEL_MODE(clksel_pkg::SEL_ONEHOT), .FIELD_SHIFT(8), .FIELD_W(4), .HALF_MASK(1'b1)) i_onehot (
    .clk(clk), .rst(rst), .wr_en(we[2]), .wr_data(wdata), .sel_reg(sel_c),
    .src_clk(src), .clk_out(out_c), .switch_busy(busy_c), .active_idx(act_c));
  clksrc_sel_mux #(.SEL_MODE(clksel_pkg::SEL_ZERO), .FIELD_SHIFT(0), .FIELD_W(2), .LOCKED(1'b1)) i_locked (
    .clk(clk), .rst(rst), .wr_en(we[3]), .wr_data(wdata), .sel_reg(sel_d),
    .src_clk(src), .clk_out(out_d), .switch_busy(busy_d), .active_idx(act_d));

  int n_chk = 0;
  int n_bad = 0;
  int glitches = 0;
  int exp_q[$];
  logic prev_busy_a = 1'b1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_per(input string req, input real p, input real e);
    n_chk++;
    if (p < e - 0.5 || p > e + 0.5) begin
      n_bad++;
      $display("FAIL %s actual period=%0.2f expected=%0.2f", req, p, e);
    end
  endtask

  // scoreboard monitor: on each completed switch of the main instance
  always @(negedge clk) begin
    if (!rst && prev_busy_a && !busy_a) begin
      if (exp_q.size() == 0) chk("R8 unexpected switch end", 32'(act_a), 32'hFFFF_FFFF);
      else chk("R8 scoreboard active index", 32'(act_a), 32'(exp_q.pop_front()));
    end
    prev_busy_a = busy_a;
  end

  // short-pulse detectors (R9)
  real last_a = 0.0;
  real last_c = 0.0;
  always @(out_a) begin
    if (!rst && last_a > 0.0 && ($realtime - last_a) < 4.9) glitches++;
    last_a = $realtime;
  end
  always @(out_c) begin
    if (!rst && last_c > 0.0 && ($realtime - last_c) < 4.9) glitches++;
    last_c = $realtime;
  end

  task automatic wr(input int which, input logic [31:0] d);
    @(negedge clk);
    wdata = d;
    we = 4'(1) << which;
    @(negedge clk);
    we = '0;
  endtask

  // driver for the main instance: push expected result, then write
  task automatic wr_a(input logic [31:0] d, input int exp_idx, input bit push);
    if (push) exp_q.push_back(exp_idx);
    wr(0, d);
  endtask

  task automatic wait_idle(input int which);
    for (int i = 0; i < 400; i++) begin
      logic b;
      @(negedge clk);
      b = (which == 0) ? busy_a : (which == 1) ? busy_b : (which == 2) ? busy_c : busy_d;
      if (!b) return;
    end
    chk("R8 busy timeout", 32'd1, 32'd0);
  endtask

  task automatic period_a(output real p);
    real t0;
    @(posedge out_a); t0 = $realtime;
    @(posedge out_a); p = $realtime - t0;
  endtask

  task automatic period_c(output real p);
    real t0;
    @(posedge out_c); t0 = $realtime;
    @(posedge out_c); p = $realtime - t0;
  endtask

  task automatic finish_run;
    chk("R9 no short output pulses", 32'(glitches), 32'd0);
    chk("R8 scoreboard drained", 32'(exp_q.size()), 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #1600000;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    real p;
    exp_q.push_back(0);
    repeat (20) @(negedge clk);
    rst = 1'b0;
    wait_idle(0); wait_idle(1); wait_idle(2); wait_idle(3);

    // R1 reset state
    chk("R1 reset word A", sel_a, 32'h0);
    chk("R1 reset index A", 32'(act_a), 32'd0);
    chk("R1 reset word B", sel_b, 32'h1);
    chk("R1 reset word C", sel_c, 32'h100);
    period_a(p); chk_per("R1 output follows source 0", p, 10.0);

    // R2 zero-based select, R8 busy timing
    wr_a(32'h0000_0020, 2, 1'b1);
    chk("R2 word stored", sel_a, 32'h20);
    chk("R8 busy low one edge after write", 32'(busy_a), 32'd0);
    @(negedge clk);
    chk("R8 busy high two edges after write", 32'(busy_a), 32'd1);
    chk("R8 index held while busy", 32'(act_a), 32'd0);
    wait_idle(0);
    chk("R2 index 2", 32'(act_a), 32'd2);
    period_a(p); chk_per("R9 period of source 2", p, 18.0);

    // R5 out-of-range field
    wr_a(32'h0000_0070, 0, 1'b0);
    chk("R5 word kept", sel_a, 32'h20);
    repeat (3) @(negedge clk);
    chk("R5 no switch", 32'(busy_a), 32'd0);
    chk("R5 index kept", 32'(act_a), 32'd2);

    // R2 bits outside the field are stored
    wr_a(32'h0000_A031, 3, 1'b1);
    chk("R2 full word stored", sel_a, 32'h0000_A031);
    wait_idle(0);
    chk("R2 index 3", 32'(act_a), 32'd3);
    period_a(p); chk_per("R9 period of source 3", p, 26.0);

    // R10 same source again
    wr_a(32'h0000_0030, 0, 1'b0);
    chk("R10 word stored", sel_a, 32'h30);
    repeat (3) @(negedge clk);
    chk("R10 no switch", 32'(busy_a), 32'd0);

    wr_a(32'h0000_0000, 0, 1'b1);
    wait_idle(0);
    period_a(p); chk_per("R9 back to source 0", p, 10.0);

    // R3 one-based
    wr(1, 32'd3); wait_idle(1);
    chk("R3 value 3 selects 2", 32'(act_b), 32'd2);
    wr(1, 32'd0); repeat (3) @(negedge clk);
    chk("R5 zero rejected one-based", sel_b, 32'd3);
    chk("R5 zero no switch", 32'(busy_b), 32'd0);
    wr(1, 32'd5); repeat (3) @(negedge clk);
    chk("R5 value 5 rejected", sel_b, 32'd3);
    wr(1, 32'd4); wait_idle(1);
    chk("R3 value 4 selects 3", 32'(act_b), 32'd3);
    wr(1, 32'd1); wait_idle(1);
    chk("R3 value 1 selects 0", 32'(act_b), 32'd0);

    // R4 and R6 one-hot with half-word mask
    wr(2, 32'h0F00_0800); wait_idle(2);
    chk("R6 upper half reads zero", sel_c, 32'h0000_0800);
    chk("R4 bit 3 selects 3", 32'(act_c), 32'd3);
    period_c(p); chk_per("R9 output C period", p, 26.0);
    wr(2, 32'h0F00_0600); repeat (3) @(negedge clk);
    chk("R5 two bits rejected", sel_c, 32'h0800);
    wr(2, 32'h0000_0100); repeat (3) @(negedge clk);
    chk("R6 zero mask changes nothing", sel_c, 32'h0800);
    chk("R6 zero mask no switch", 32'(busy_c), 32'd0);
    wr(2, 32'h0100_0100); repeat (3) @(negedge clk);
    chk("R5 merged two bits rejected", sel_c, 32'h0800);
    wr(2, 32'h0900_0100); wait_idle(2);
    chk("R6 partial mask word", sel_c, 32'h0100);
    chk("R4 bit 0 selects 0", 32'(act_c), 32'd0);

    // R7 locked
    wr(3, 32'd2); repeat (3) @(negedge clk);
    chk("R7 locked word", sel_d, 32'd0);
    chk("R7 locked no busy", 32'(busy_d), 32'd0);
    chk("R7 locked index", 32'(act_d), 32'd0);

    finish_run();
  end
endmodule